// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block watches the error strobes of two independent memories, each built from several banks, and keeps one captured error report per memory per error class (corrected and non-corrected), four report sets in all. Each report holds the bank that failed, the word address and the checkbits as they were read from memory. A report loads only while its interrupt flag is clear. An error that arrives while the flag is pending leaves the report as it was and sets a sticky overflow flag, which marks that an error was lost.

Every bank of each memory has its own strobe, class bit, address and checkbits. When several banks of one memory fail in the same cycle, each class captures its lowest-numbered failing bank and the overflow flag of every class involved is set. A memory that can only detect errors reports every error as non-corrected, whatever class its decoder signals. Software clears flags through a write-one-to-clear port. The interrupt request is the OR of the interrupt flags, each gated by its own enable. Capture happens only while the global ECC enable is high.

Top module: `eccErrCapture`

## Requirements
- R1: While `eccEn` is low, error strobes change no flag and no report; the clear inputs still work.
- R2: Report set s = 2*memory + class, where class 1 means non-corrected and class 0 means corrected, so set 0 is memory 0 corrected, 1 is memory 0 non-corrected, 2 is memory 1 corrected and 3 is memory 1 non-corrected. Bank b of memory m uses strobe index m*NUM_BANKS+b. A report loads bank, address, checkbits and valid together, and they are visible one clock after the strobe.
- R3: An error that arrives while the matching interrupt flag is set leaves the report unchanged and sets the matching overflow flag.
- R4: An error that arrives while the matching interrupt flag is clear loads the report and sets the interrupt flag. Whenever an interrupt flag is set, its report valid bit is set.
- R5: When two or more banks of one memory signal the same class in one cycle, the lowest-numbered bank is captured and that class's overflow flag is set.
- R6: When two or more banks of one memory signal errors in one cycle, the overflow flag of each class with an error in that memory is set. Single errors in different memories set no overflow.
- R7: The captured checkbits are the input checkbits of the chosen bank, copied without change.
- R8: A memory whose bit in `MEM_CORRECTS` is 0 (memory 1 by default) reports every error as non-corrected and ignores its class inputs, so its corrected set never loads.
- R9: Interrupt and overflow flags are sticky and clear only when their bit is written as one. A new error in the same cycle as a clear keeps the flag set.
- R10: `irq` is high exactly when some interrupt flag and its enable bit are both set.
- R11: A synchronous active-low reset clears all flags and all report fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| eccEn | input | 1 | Global enable for error capture |
| memErrValid | input | 2*NUM_BANKS | Per-bank error strobe, index m*NUM_BANKS+b |
| memErrUncorr | input | 2*NUM_BANKS | Per-bank class: 1 non-corrected, 0 corrected |
| memErrAddr | input | 2*NUM_BANKS*ADDR_W | Per-bank failing word address |
| memErrChk | input | 2*NUM_BANKS*CHK_W | Per-bank checkbits as read |
| clrIntFlag | input | 4 | Write-one-to-clear for the interrupt flags |
| clrOvfFlag | input | 4 | Write-one-to-clear for the overflow flags |
| irqEnable | input | 4 | Per-flag interrupt enable |
| rptValid | output | 4 | Report set holds a capture |
| rptBank | output | 4*BANK_W | Captured bank index per set |
| rptAddr | output | 4*ADDR_W | Captured address per set |
| rptChk | output | 4*CHK_W | Captured checkbits per set |
| intFlag | output | 4 | Sticky interrupt flags |
| ovfFlag | output | 4 | Sticky lost-error flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is held low at the first clock edge and that the strobe, class, clear and enable inputs are stable around each rising edge. The class, address and checkbit lanes are taken to matter only where their strobe is high. The bench drives every input on the falling edge and holds each error strobe for exactly one cycle. It leaves the lanes of idle banks at zero, so each capture can be traced to a single chosen bank.

// File: rtl/eccCapPkg.sv
`timescale 1ns/1ps
package eccCapPkg;
  localparam int NUM_MEMS   = 2;
  localparam int NUM_CLS    = 2;
  localparam int NUM_SETS   = NUM_MEMS * NUM_CLS;
  localparam int CLS_CORR   = 0;
  localparam int CLS_UNCORR = 1;

  // Strobes from control to datapath, one bit per report set.
  typedef struct packed {
    logic [NUM_SETS-1:0] load;
    logic [NUM_SETS-1:0] flagSet;
    logic [NUM_SETS-1:0] ovfSet;
  } capStrobe_t;
endpackage

// File: rtl/eccCapPrio.sv
`timescale 1ns/1ps
module eccCapPrio #(
  parameter int WIDTH = 4,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // Lowest set bit wins: scan downward, the last hit overwrites.
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/eccCapCtrl.sv
`timescale 1ns/1ps
module eccCapCtrl
  import eccCapPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter logic [NUM_MEMS-1:0] MEM_CORRECTS = 2'b01,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LANES  = NUM_MEMS * NUM_BANKS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       eccEn,
  input  logic [LANES-1:0]           errValid,
  input  logic [LANES-1:0]           errUncorr,
  input  logic [NUM_SETS-1:0]        clrIntFlag,
  input  logic [NUM_SETS-1:0]        clrOvfFlag,
  output capStrobe_t                 strobe,
  output logic [NUM_SETS*BANK_W-1:0] selBank,
  output logic [NUM_SETS-1:0]        intFlag,
  output logic [NUM_SETS-1:0]        ovfFlag
);
  logic [NUM_SETS-1:0] intFlagQ;
  logic [NUM_SETS-1:0] ovfFlagQ;
  logic [NUM_SETS-1:0] loadVec;
  logic [NUM_SETS-1:0] hitVec;
  logic [NUM_SETS-1:0] ovfVec;
  logic [NUM_MEMS-1:0] memMany;

  for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
    logic [NUM_BANKS-1:0] vld;
    logic [NUM_BANKS-1:0] effUnc;
    assign vld = errValid[m*NUM_BANKS +: NUM_BANKS] & {NUM_BANKS{eccEn}};
    // A detect-only memory forces every error into the non-corrected class.
    assign effUnc = errUncorr[m*NUM_BANKS +: NUM_BANKS]
                  | {NUM_BANKS{~MEM_CORRECTS[m]}};
    assign memMany[m] = |(vld & (vld - NUM_BANKS'(1)));

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      localparam int SET = m * NUM_CLS + c;
      logic [NUM_BANKS-1:0] clsReq;
      logic [BANK_W-1:0]    idx;
      logic                 any;
      if (c == CLS_UNCORR) begin : g_unc
        assign clsReq = vld & effUnc;
      end else begin : g_cor
        assign clsReq = vld & ~effUnc;
      end
      eccCapPrio #(.WIDTH(NUM_BANKS)) u_prio (
        .req (clsReq),
        .idx (idx),
        .any (any)
      );
      assign selBank[SET*BANK_W +: BANK_W] = idx;
      assign hitVec[SET]  = any;
      assign loadVec[SET] = any & ~intFlagQ[SET];
      assign ovfVec[SET]  = any & (intFlagQ[SET] | memMany[m]);
    end
  end

  assign strobe = '{load: loadVec, flagSet: hitVec, ovfSet: ovfVec};

  // Sticky flags: a new event in the same cycle beats the clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intFlagQ <= '0;
      ovfFlagQ <= '0;
    end else begin
      intFlagQ <= (intFlagQ & ~clrIntFlag) | strobe.flagSet;
      ovfFlagQ <= (ovfFlagQ & ~clrOvfFlag) | strobe.ovfSet;
    end
  end

  assign intFlag = intFlagQ;
  assign ovfFlag = ovfFlagQ;
endmodule

// File: rtl/eccCapData.sv
`timescale 1ns/1ps
module eccCapData
  import eccCapPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int CHK_W     = 8,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LANES  = NUM_MEMS * NUM_BANKS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [LANES*ADDR_W-1:0]    errAddr,
  input  logic [LANES*CHK_W-1:0]     errChk,
  input  capStrobe_t                 strobe,
  input  logic [NUM_SETS*BANK_W-1:0] selBank,
  output logic [NUM_SETS-1:0]        rptValid,
  output logic [NUM_SETS*BANK_W-1:0] rptBank,
  output logic [NUM_SETS*ADDR_W-1:0] rptAddr,
  output logic [NUM_SETS*CHK_W-1:0]  rptChk
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam int BASE = (s / NUM_CLS) * NUM_BANKS;
    logic [BANK_W-1:0] sel;
    logic [ADDR_W-1:0] addrMux;
    logic [CHK_W-1:0]  chkMux;
    logic              validQ;
    logic [BANK_W-1:0] bankQ;
    logic [ADDR_W-1:0] addrQ;
    logic [CHK_W-1:0]  chkQ;

    assign sel = selBank[s*BANK_W +: BANK_W];
    always_comb begin
      addrMux = errAddr[(BASE + int'(sel))*ADDR_W +: ADDR_W];
      chkMux  = errChk[(BASE + int'(sel))*CHK_W +: CHK_W];
    end

    // All fields of one report move on the same edge.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        bankQ  <= '0;
        addrQ  <= '0;
        chkQ   <= '0;
      end else if (strobe.load[s]) begin
        validQ <= 1'b1;
        bankQ  <= sel;
        addrQ  <= addrMux;
        chkQ   <= chkMux;
      end
    end

    assign rptValid[s]                 = validQ;
    assign rptBank[s*BANK_W +: BANK_W] = bankQ;
    assign rptAddr[s*ADDR_W +: ADDR_W] = addrQ;
    assign rptChk[s*CHK_W +: CHK_W]    = chkQ;
  end
endmodule

// File: rtl/eccErrCapture.sv
`timescale 1ns/1ps
module eccErrCapture
  import eccCapPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int CHK_W     = 8,
  parameter logic [1:0] MEM_CORRECTS = 2'b01,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LANES  = 2 * NUM_BANKS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  eccEn,
  input  logic [LANES-1:0]      memErrValid,
  input  logic [LANES-1:0]      memErrUncorr,
  input  logic [LANES*ADDR_W-1:0] memErrAddr,
  input  logic [LANES*CHK_W-1:0]  memErrChk,
  input  logic [3:0]            clrIntFlag,
  input  logic [3:0]            clrOvfFlag,
  input  logic [3:0]            irqEnable,
  output logic [3:0]            rptValid,
  output logic [4*BANK_W-1:0]   rptBank,
  output logic [4*ADDR_W-1:0]   rptAddr,
  output logic [4*CHK_W-1:0]    rptChk,
  output logic [3:0]            intFlag,
  output logic [3:0]            ovfFlag,
  output logic                  irq
);
  capStrobe_t                 strobe;
  logic [NUM_SETS*BANK_W-1:0] selBank;

  eccCapCtrl #(
    .NUM_BANKS    (NUM_BANKS),
    .MEM_CORRECTS (MEM_CORRECTS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .eccEn      (eccEn),
    .errValid   (memErrValid),
    .errUncorr  (memErrUncorr),
    .clrIntFlag (clrIntFlag),
    .clrOvfFlag (clrOvfFlag),
    .strobe     (strobe),
    .selBank    (selBank),
    .intFlag    (intFlag),
    .ovfFlag    (ovfFlag)
  );

  eccCapData #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .CHK_W     (CHK_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .errAddr  (memErrAddr),
    .errChk   (memErrChk),
    .strobe   (strobe),
    .selBank  (selBank),
    .rptValid (rptValid),
    .rptBank  (rptBank),
    .rptAddr  (rptAddr),
    .rptChk   (rptChk)
  );

  assign irq = |(intFlag & irqEnable);
endmodule

// File: rtl/eccErrCaptureChk.sv
`timescale 1ns/1ps
module eccErrCaptureChk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int CHK_W     = 8,
  parameter logic [1:0] MEM_CORRECTS = 2'b01,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LANES  = 2 * NUM_BANKS
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  eccEn,
  input logic [LANES-1:0]      memErrValid,
  input logic [LANES-1:0]      memErrUncorr,
  input logic [LANES*ADDR_W-1:0] memErrAddr,
  input logic [LANES*CHK_W-1:0]  memErrChk,
  input logic [3:0]            clrIntFlag,
  input logic [3:0]            clrOvfFlag,
  input logic [3:0]            irqEnable,
  input logic [3:0]            rptValid,
  input logic [4*BANK_W-1:0]   rptBank,
  input logic [4*ADDR_W-1:0]   rptAddr,
  input logic [4*CHK_W-1:0]    rptChk,
  input logic [3:0]            intFlag,
  input logic [3:0]            ovfFlag,
  input logic                  irq
);
  // R11: reset empties every flag and report.
  p_reset_clears_r11: assert property (@(posedge clk)
    !rstN |=> (intFlag == 4'b0) && (ovfFlag == 4'b0) && (rptValid == 4'b0));

  // R1: with capture disabled and no clear, the flags do not move.
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!eccEn && (clrIntFlag == 4'b0)) |=> $stable(intFlag));

  // R10: no enabled pending flag means no request.
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((intFlag & irqEnable) == 4'b0) |-> !irq);

  for (genvar s = 0; s < 4; s++) begin : g_set
    localparam int MEM = s / 2;
    localparam bit UNC = (s % 2) == 1;
    logic [NUM_BANKS-1:0] vld;
    logic [NUM_BANKS-1:0] unc;
    logic                 hitS;
    assign vld  = memErrValid[MEM*NUM_BANKS +: NUM_BANKS];
    assign unc  = memErrUncorr[MEM*NUM_BANKS +: NUM_BANKS]
                | {NUM_BANKS{~MEM_CORRECTS[MEM]}};
    assign hitS = UNC ? |(vld & unc) : |(vld & ~unc);

    // R3: a pending flag freezes its report.
    p_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
      intFlag[s] |=> $stable(rptAddr[s*ADDR_W +: ADDR_W])
                  && $stable(rptBank[s*BANK_W +: BANK_W])
                  && $stable(rptChk[s*CHK_W +: CHK_W]));

    // R3: an error hitting a pending flag is recorded as lost.
    p_ovf_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
      (eccEn && intFlag[s] && hitS) |=> ovfFlag[s]);

    // R4: a set flag always has a report behind it.
    p_flag_has_report_r4: assert property (@(posedge clk) disable iff (!rstN)
      intFlag[s] |-> rptValid[s]);

    // R9: flags hold until written with one.
    p_int_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (intFlag[s] && !clrIntFlag[s]) |=> intFlag[s]);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[s] && !clrOvfFlag[s]) |=> ovfFlag[s]);

    // R8: a detect-only memory never fills its corrected set.
    if (!UNC && !MEM_CORRECTS[MEM]) begin : g_detonly
      p_no_corr_r8: assert property (@(posedge clk) disable iff (!rstN)
        !intFlag[s] && !rptValid[s]);
    end
  end
endmodule

bind eccErrCapture eccErrCaptureChk #(
  .NUM_BANKS    (NUM_BANKS),
  .ADDR_W       (ADDR_W),
  .CHK_W        (CHK_W),
  .MEM_CORRECTS (MEM_CORRECTS)
) u_chk (.*);

// File: tb/eccErrCapture_tb.sv
`timescale 1ns/1ps
module eccErrCapture_tb;
  localparam int NB = 4;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam int BW = 2;
  localparam int LN = 2 * NB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eccEn = 1'b0;
  logic [LN-1:0]    memErrValid = '0;
  logic [LN-1:0]    memErrUncorr = '0;
  logic [LN*AW-1:0] memErrAddr = '0;
  logic [LN*CW-1:0] memErrChk = '0;
  logic [3:0] clrIntFlag = '0;
  logic [3:0] clrOvfFlag = '0;
  logic [3:0] irqEnable = '0;
  logic [3:0] rptValid;
  logic [4*BW-1:0] rptBank;
  logic [4*AW-1:0] rptAddr;
  logic [4*CW-1:0] rptChk;
  logic [3:0] intFlag;
  logic [3:0] ovfFlag;
  logic irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eccErrCapture u_dut (
    .clk(clk), .rstN(rstN), .eccEn(eccEn),
    .memErrValid(memErrValid), .memErrUncorr(memErrUncorr),
    .memErrAddr(memErrAddr), .memErrChk(memErrChk),
    .clrIntFlag(clrIntFlag), .clrOvfFlag(clrOvfFlag), .irqEnable(irqEnable),
    .rptValid(rptValid), .rptBank(rptBank), .rptAddr(rptAddr), .rptChk(rptChk),
    .intFlag(intFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    memErrValid = '0; memErrUncorr = '0; memErrAddr = '0; memErrChk = '0;
    clrIntFlag = '0; clrOvfFlag = '0;
  endtask

  task automatic setErr(int m, int b, bit unc, logic [AW-1:0] a, logic [CW-1:0] c);
    int idx = m * NB + b;
    memErrValid[idx] = 1'b1;
    memErrUncorr[idx] = unc;
    memErrAddr[idx*AW +: AW] = a;
    memErrChk[idx*CW +: CW] = c;
  endtask

  task automatic clearAll();
    clrIntFlag = 4'hF; clrOvfFlag = 4'hF;
    tick();
    idleInputs();
  endtask

  function automatic logic [31:0] bankOf(int s); return 32'(rptBank[s*BW +: BW]); endfunction
  function automatic logic [31:0] addrOf(int s); return 32'(rptAddr[s*AW +: AW]); endfunction
  function automatic logic [31:0] chkOf(int s);  return 32'(rptChk[s*CW +: CW]);  endfunction

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    check("R11", "intFlag after reset", 32'(intFlag), 0);
    check("R11", "ovfFlag after reset", 32'(ovfFlag), 0);
    check("R11", "rptValid after reset", 32'(rptValid), 0);
    check("R11", "irq after reset", 32'(irq), 0);
  endtask

  task automatic testDisabled();
    eccEn = 1'b0;
    setErr(0, 1, 1'b0, 12'h0AB, 8'h11);
    setErr(1, 2, 1'b1, 12'h0CD, 8'h22);
    tick(); idleInputs();
    check("R1", "intFlag while disabled", 32'(intFlag), 0);
    check("R1", "rptValid while disabled", 32'(rptValid), 0);
    check("R1", "ovfFlag while disabled", 32'(ovfFlag), 0);
  endtask

  task automatic testCapture();
    eccEn = 1'b1;
    setErr(0, 2, 1'b0, 12'h123, 8'h5A);
    tick(); idleInputs();
    check("R4", "intFlag after first error", 32'(intFlag), 32'h1);
    check("R2", "rptValid set 0", 32'(rptValid), 32'h1);
    check("R2", "bank set 0", bankOf(0), 2);
    check("R2", "addr set 0", addrOf(0), 32'h123);
    check("R7", "checkbits set 0", chkOf(0), 32'h5A);
    check("R4", "no overflow on first error", 32'(ovfFlag), 0);
  endtask

  task automatic testPending();
    setErr(0, 3, 1'b0, 12'h777, 8'hC3);
    tick(); idleInputs();
    check("R3", "addr frozen", addrOf(0), 32'h123);
    check("R3", "bank frozen", bankOf(0), 2);
    check("R3", "checkbits frozen", chkOf(0), 32'h5A);
    check("R3", "overflow on pending flag", 32'(ovfFlag), 32'h1);
  endtask

  task automatic testIrq();
    irqEnable = 4'b0000; #1;
    check("R10", "irq with no enable", 32'(irq), 0);
    irqEnable = 4'b0010; #1;
    check("R10", "irq with other enable", 32'(irq), 0);
    irqEnable = 4'b0001; #1;
    check("R10", "irq with matching enable", 32'(irq), 1);
    irqEnable = 4'b0000;
  endtask

  task automatic testClear();
    setErr(0, 0, 1'b0, 12'h456, 8'h0F);
    clrIntFlag = 4'b0001;
    tick(); idleInputs();
    check("R9", "new error beats clear", 32'(intFlag[0]), 1);
    check("R3", "report frozen during clear race", addrOf(0), 32'h123);
    clrIntFlag = 4'b0001;
    tick(); idleInputs();
    check("R9", "write one clears intFlag", 32'(intFlag), 0);
    check("R9", "overflow untouched by int clear", 32'(ovfFlag), 32'h1);
    check("R9", "report kept after clear", 32'(rptValid[0]), 1);
    clrOvfFlag = 4'b0001;
    tick(); idleInputs();
    check("R9", "write one clears ovfFlag", 32'(ovfFlag), 0);
  endtask

  task automatic testSameClass();
    setErr(0, 3, 1'b1, 12'h333, 8'hBB);
    setErr(0, 1, 1'b1, 12'h111, 8'hAA);
    tick(); idleInputs();
    check("R5", "intFlag set 1", 32'(intFlag), 32'h2);
    check("R5", "lowest bank captured", bankOf(1), 1);
    check("R5", "lowest bank addr", addrOf(1), 32'h111);
    check("R7", "lowest bank checkbits", chkOf(1), 32'hAA);
    check("R5", "overflow for lost bank", 32'(ovfFlag), 32'h2);
    clearAll();
  endtask

  task automatic testMixed();
    setErr(0, 0, 1'b0, 12'h0A0, 8'h01);
    setErr(0, 2, 1'b1, 12'h0B0, 8'h02);
    tick(); idleInputs();
    check("R6", "both classes flagged", 32'(intFlag), 32'h3);
    check("R6", "corrected bank", bankOf(0), 0);
    check("R6", "non-corrected bank", bankOf(1), 2);
    check("R6", "non-corrected addr", addrOf(1), 32'h0B0);
    check("R6", "overflow on both classes", 32'(ovfFlag), 32'h3);
    clearAll();
  endtask

  task automatic testDetectOnly();
    setErr(1, 1, 1'b0, 12'h5C5, 8'h7E);
    setErr(0, 1, 1'b0, 12'h010, 8'h20);
    tick(); idleInputs();
    check("R8", "memory 1 error lands in non-corrected set", 32'(intFlag), 32'h9);
    check("R8", "memory 1 corrected set empty", 32'(rptValid[2]), 0);
    check("R8", "memory 1 bank", bankOf(3), 1);
    check("R8", "memory 1 addr", addrOf(3), 32'h5C5);
    check("R7", "memory 1 checkbits", chkOf(3), 32'h7E);
    check("R6", "single errors in two memories no overflow", 32'(ovfFlag), 0);
  endtask

  task automatic testMidReset();
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    check("R11", "flags cleared by reset", 32'(intFlag), 0);
    check("R11", "reports cleared by reset", 32'(rptValid), 0);
    check("R11", "addr cleared by reset", addrOf(3), 0);
  endtask

  initial begin
    tick();
    testReset();
    testDisabled();
    testCapture();
    testPending();
    testIrq();
    testClear();
    testSameClass();
    testMixed();
    testDetectOnly();
    testMidReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule